// File: doc/BRIEF.md
# Error-Feedback DC Blocking Filter

This block strips the DC component from a stream of unsigned fixed-point samples. It is a first-order high-pass recursion that takes one sample per clock with no stall. Its output is a narrower signed word. The whole loop closes within a single cycle: the first difference of the input, the constant-coefficient product of the previous output, the carried residue and the requantizer.

Requantization truncates toward minus infinity. The fraction bits it discards are stored and added back into the next sum. This pushes the rounding noise away from zero frequency, so truncation cannot leave a standing offset on a constant input. The pole coefficient is a compile-time fraction, COEF / 2^CF. It is realised as shifted copies of the previous output. A parameter chooses a plain bit-per-term form or a signed-digit recoding, in which a run of ones costs one subtraction and one addition.

The input is IN_W bits with one integer bit. The output is OUT_W bits in two's complement with four integer bits including the sign, which leaves OUT_W-4 fraction bits. DROP = (IN_W-1) - (OUT_W-4) input fraction bits are removed. The internal sum keeps CF extra fraction bits, so the product is exact before truncation. With S = DROP + CF, the carried residue is S bits wide.

Top module: `dc_block_ef`

## Requirements
- R1: A synchronous reset clears the previous input, previous output and carried residue to zero, and drives out_valid to 0 and out_sample to 0. The first sample after reset therefore yields floor(x / 2^DROP).
- R2: out_valid equals the in_valid of the previous clock. A sample can be accepted on every clock, back to back.
- R3: In units of 2^-(IN_W-1+CF), each accepted sample forms v = (x - x_prev)·2^CF + y_prev·COEF·2^DROP + r_prev. The output is y = floor(v / 2^S).
- R4: The residue r = v - y·2^S lies in [0, 2^S). It is stored and added into the next accepted sample's sum. Example with defaults: after reset, x=64 gives y=0, and then x=128 gives y=1.
- R5: While in_valid is 0, the stored state does not change and out_sample holds its value. The next accepted sample uses the last accepted input as x_prev.
- R6: On a constant input after settling, the output carries no truncation offset. The magnitude of the sum of 512 consecutive outputs is at most 4·2^CF/(2^CF - COEF).
- R7: Every valid output satisfies |out_sample| <= 2^(OUT_W-2) + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | IN_W | Unsigned input, one integer bit |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | OUT_W | Signed filtered output, four integer bits |

## Verification
Each output is due exactly one clock after its sample is accepted, because the only register on the path is the one that holds y_prev and drives out_sample. The bench drives inputs on the falling edge and samples one time unit after the following rising edge. It compares against an integer model of the recursion, advanced only for accepted samples. Idle cycles are checked at that same point for a low out_valid and an unchanged out_sample. The reset state is read while reset is held, and the DC-offset bound is summed over outputs taken one per accepted sample after a long settle.

// File: rtl/dc_block_ef.sv
module dc_block_ef #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12,
  parameter int CF    = 6,
  parameter int COEF  = 62,
  parameter bit CSD   = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int F    = IN_W - 1;
  localparam int OF   = OUT_W - 4;
  localparam int DROP = F - OF;
  localparam int S    = DROP + CF;
  localparam int V_W  = F + CF + 5;
  localparam int D_W  = IN_W + 1;

  // Digit masks of the coefficient: {negative digits, positive digits}.
  // With recoding, a run of ones becomes -1 at its bottom and +1 above its top.
  function automatic logic [2*(CF+1)-1:0] coef_digits(input bit recode);
    logic [CF:0] pos, neg;
    logic [CF+1:0] c;
    int carry, s, nb;
    pos = '0; neg = '0;
    c = (CF+2)'(COEF);
    carry = 0;
    if (!recode) begin
      pos = c[CF:0];
    end else begin
      for (int i = 0; i <= CF; i++) begin
        s  = int'(c[i]) + carry;
        nb = int'(c[i+1]);
        if (s == 1 && nb == 1) begin
          neg[i] = 1'b1; carry = 1;
        end else if (s == 1) begin
          pos[i] = 1'b1; carry = 0;
        end else if (s == 2) begin
          carry = 1;
        end else begin
          carry = 0;
        end
      end
    end
    return {neg, pos};
  endfunction

  localparam logic [2*(CF+1)-1:0] DIG = coef_digits(CSD);
  localparam logic [CF:0] POS = DIG[CF:0];
  localparam logic [CF:0] NEG = DIG[2*(CF+1)-1:CF+1];

  logic [IN_W-1:0]         x_prev;
  logic signed [OUT_W-1:0] y_prev;
  logic [S-1:0]            resid;
  logic                    vld;

  logic signed [D_W-1:0] diff;
  logic signed [V_W-1:0] diff_w, y_w, prod, vsum;

  assign diff   = $signed({1'b0, in_sample}) - $signed({1'b0, x_prev});
  assign diff_w = {{(V_W-D_W){diff[D_W-1]}}, diff} <<< CF;
  assign y_w    = {{(V_W-OUT_W){y_prev[OUT_W-1]}}, y_prev};

  always_comb begin
    prod = '0;
    for (int i = 0; i <= CF; i++) begin
      if (POS[i]) prod = prod + (y_w <<< (i + DROP));
      if (NEG[i]) prod = prod - (y_w <<< (i + DROP));
    end
  end

  assign vsum = diff_w + prod + {{(V_W-S){1'b0}}, resid};

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev <= '0;
      y_prev <= '0;
      resid  <= '0;
      vld    <= 1'b0;
    end else begin
      vld <= in_valid;
      if (in_valid) begin
        x_prev <= in_sample;
        y_prev <= vsum[S+OUT_W-1:S];
        resid  <= vsum[S-1:0];
      end
    end
  end

  assign out_valid  = vld;
  assign out_sample = y_prev;
endmodule

module dc_block_ef_chk #(
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample
);
  localparam logic signed [OUT_W-1:0] LIM = OUT_W'((1 << (OUT_W-2)) + 2);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && out_sample == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sample));

  assert_out_bound_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sample <= LIM && out_sample >= -LIM));
endmodule

bind dc_block_ef dc_block_ef_chk #(.OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/dc_block_ef_tb_top.sv
module dc_block_ef_tb_top;
  localparam int IN_W  = 16;
  localparam int OUT_W = 12;
  localparam int CF    = 6;
  localparam int COEF  = 62;
  localparam int F     = IN_W - 1;
  localparam int DROP  = F - (OUT_W - 4);
  localparam int S     = DROP + CF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_sample = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  longint mx = 0, my = 0, mr = 0;
  longint dc_sum;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dc_block_ef #(.IN_W(IN_W), .OUT_W(OUT_W), .CF(CF), .COEF(COEF), .CSD(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(input longint x);
    longint v, ny;
    v  = (x - mx) * (64'sd1 <<< CF) + my * COEF * (64'sd1 <<< DROP) + mr;
    ny = v >>> S;
    mr = v - ny * (64'sd1 <<< S);
    my = ny;
    mx = x;
  endtask

  task automatic push(input bit v, input logic [IN_W-1:0] x);
    longint held;
    held = longint'(out_sample);
    @(negedge clk);
    in_valid  = v;
    in_sample = x;
    @(posedge clk);
    #1;
    check("R2 out_valid", longint'(out_valid), longint'(v));
    if (v) begin
      model_step(longint'(x));
      check("R3 sample", longint'(out_sample), my);
      if (out_sample > (1 <<< (OUT_W-2)) + 2 || out_sample < -((1 <<< (OUT_W-2)) + 2))
        check("R7 bound", longint'(out_sample), 0);
    end else begin
      check("R5 hold", longint'(out_sample), held);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 valid", longint'(out_valid), 0);
    check("R1 sample", longint'(out_sample), 0);
    @(negedge clk);
    rst = 1'b0;
    mx = 0; my = 0; mr = 0;
  endtask

  task automatic lfsr_next();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    do_reset();

    // R1: first sample after reset uses zero state
    push(1'b1, 16'hFFFF);
    check("R1 first", longint'(out_sample), longint'(16'hFFFF) >>> DROP);

    // R4: residue carried into next sum
    do_reset();
    push(1'b1, 16'd64);
    check("R4 first", longint'(out_sample), 0);
    push(1'b1, 16'd128);
    check("R4 carried", longint'(out_sample), 1);

    // R3: DC plateaus
    for (int lv = 0; lv < 8; lv++)
      for (int k = 0; k < 40; k++) push(1'b1, 16'(lv * 9000 + 17));

    // R7: full-scale alternation
    for (int k = 0; k < 64; k++) push(1'b1, (k % 2) ? 16'hFFFF : 16'h0000);

    // R5: idle with changing input, then resume
    for (int k = 0; k < 5; k++) push(1'b0, 16'(k * 777));
    push(1'b1, 16'h1234);

    // R2/R3/R5: pseudo-random data with random gaps
    for (int k = 0; k < 3000; k++) begin
      lfsr_next();
      push(lfsr[0] | lfsr[3], lfsr);
    end

    // R3: near-exhaustive ramps over the input range
    do_reset();
    for (int k = 0; k < 65536; k++) push(1'b1, 16'(k));
    for (int k = 65535; k >= 0; k -= 3) push(1'b1, 16'(k));

    // R6: step down then constant; sum must stay bounded
    for (int k = 0; k < 300; k++) push(1'b1, 16'hFFFF);
    for (int k = 0; k < 600; k++) push(1'b1, 16'h0100);
    dc_sum = 0;
    for (int k = 0; k < 512; k++) begin
      push(1'b1, 16'h0100);
      dc_sum += longint'(out_sample);
    end
    if (dc_sum < 0) dc_sum = -dc_sum;
    check("R6 dc sum bounded", longint'(dc_sum <= 4 * (1 <<< CF) / ((1 <<< CF) - COEF)), 1);

    // R1: reset in mid-stream
    do_reset();
    push(1'b1, 16'h8000);
    check("R1 after mid reset", longint'(out_sample), longint'(16'h8000) >>> DROP);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule